// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Sequencer

This block sits in an SDRAM controller between the request arbiter and the command and DQ pins. It handles the move from a READ burst to a following WRITE. It picks the cycle in which the WRITE command goes out and decides whether the READ burst has to be cut short. It also drives the DQM mask so that the memory stops putting read data on the bus before the controller starts driving write data.

A read starts with a one-cycle strobe that carries a bank, a column and a burst length. A write is posted with a one-cycle strobe that carries a bank, a column and a single data word. The block holds the write until it can issue it. If a read is still in flight, the write cuts the burst at the earliest word the mask can still reach. The read mask acts two clocks late and the write mask acts at once, so the block raises DQM ahead of the WRITE and drops it in the WRITE cycle. A configuration input adds one idle cycle between the last wanted read word and the WRITE. Use it on boards where the controller's drivers may turn on before the memory's drivers turn off. The CAS latency is a parameter, either 2 or 3.

Top module: `rdwr_turnaround`

## Requirements
- R1: Commands on `cmdOut` are encoded as {RAS_n, CAS_n, WE_n}: READ = 3'b101, WRITE = 3'b100, NOP = 3'b111. After reset the block issues NOP, with DQM low and the DQ output enable low. A read strobe seen while the block is idle produces READ in the next cycle (cycle 0), carrying the strobe's bank and column. Every cycle that is neither the READ nor the WRITE is a NOP.
- R2: With a read of length N in flight, read words are due in cycles CL through E = CL+N-1. Here CL is the CAS latency and cycles are counted from the READ. A write strobe arrives in cycle j; a strobe at or before cycle 0 counts as j = 0. The last read word delivered unmasked is then L = min(max(j+2, CL), E).
- R3: The WRITE issues in cycle W = L+1 when the gap input is low and W = L+2 when it is high. It never issues earlier than cycle j+1.
- R4: When L < E, DQM is high from cycle L-1 through cycle W-1, so it is always high in the cycle just before the WRITE.
- R5: DQM is low in the WRITE cycle.
- R6: When L = E, the burst ends by itself (this includes every burst of length 1) and DQM stays low throughout.
- R7: `dqOe` is high only in the WRITE cycle, and `dqOut` then carries the posted data. No cycle where `dqOe` is high holds unmasked read data. A read word counts as unmasked in cycle t when DQM was low in cycle t-2 and t < W. When the gap input is high, cycle W-1 also holds no unmasked read data.
- R8: A write strobe seen while idle, with no read strobe, gives WRITE in the next cycle. A read strobe seen while a read is in flight is ignored. A write strobe seen while a write is already pending is ignored, and the first write's data is the data sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdStart | input | 1 | One-cycle read request strobe |
| rdBank | input | BANK_W | Read bank |
| rdCol | input | COL_W | Read column |
| rdLen | input | $clog2(BL_MAX+1) | Read burst length, 1 to BL_MAX |
| wrStart | input | 1 | One-cycle write request strobe |
| wrBank | input | BANK_W | Write bank |
| wrCol | input | COL_W | Write column |
| wrData | input | DATA_W | Write data word |
| cfgGap | input | 1 | Adds one idle cycle before the WRITE |
| cmdOut | output | 3 | {RAS_n, CAS_n, WE_n} command |
| bankOut | output | BANK_W | Bank for the command (zero on NOP) |
| addrOut | output | COL_W | Column for the command (zero on NOP) |
| dqmOut | output | 1 | DQ mask |
| dqOe | output | 1 | Controller DQ output enable |
| dqOut | output | DATA_W | Write data onto DQ |

## Verification
Two events can fall in the same cycle, and they pull in different directions. The first is a write strobe that arrives with the read strobe, or with the last edge of a running read. The second is the end of that read. The bench provokes both: it sends the write together with the read, and it also sends it on every later cycle of the burst, up to the cycles just after the read ends. It sweeps every burst length and both settings of the gap input. In each case the bench predicts L and W by arithmetic. It rebuilds from the sampled DQM which read words the memory would still drive, and it checks that none of them meets the output enable or, when the gap input is high, the cycle just before the WRITE.

// File: rtl/rdwr_turn_pkg.sv
package rdwr_turn_pkg;

  typedef enum logic [2:0] {
    CMD_WRITE = 3'b100,
    CMD_READ  = 3'b101,
    CMD_NOP   = 3'b111
  } sdCmd_e;

  // strobes from the sequencing control to the pin datapath, all for the next cycle
  typedef struct packed {
    logic issueRd;   // READ goes out next cycle
    logic issueWr;   // WRITE goes out next cycle
    logic wrCut;     // that WRITE truncates a running burst
    logic dqmNext;   // DQM level for next cycle
    logic capWr;     // latch the posted write fields now
  } seqStrobe_t;

endpackage

// File: rtl/rdwr_turn_ctrl.sv
module rdwr_turn_ctrl
  import rdwr_turn_pkg::*;
#(
  parameter int CAS_LAT = 3,
  parameter int BL_MAX  = 8,
  parameter int LEN_W   = $clog2(BL_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdStart,
  input  logic [LEN_W-1:0] rdLen,
  input  logic             wrStart,
  input  logic             cfgGap,
  output seqStrobe_t       stb
);

  localparam int K_W = $clog2(CAS_LAT + BL_MAX + 4);
  localparam logic [K_W-1:0] CL_K = K_W'(CAS_LAT);

  logic           busy, sched, maskOn, wrPend;
  logic [K_W-1:0] k, wK, dqmK, lastK;

  logic           pendNow, doSched, cutNew, effSched, effMask, endRead;
  logic [K_W-1:0] kNext, near, lPick, lFin, wBase, wCand, effW, effDqmK;

  always_comb begin
    pendNow  = wrPend | wrStart;
    kNext    = k + K_W'(1);
    near     = k + K_W'(2);
    lPick    = (near > CL_K) ? near : CL_K;
    cutNew   = lPick < lastK;
    lFin     = cutNew ? lPick : lastK;
    wBase    = lFin + K_W'(1) + K_W'(cfgGap);
    wCand    = (wBase < kNext) ? kNext : wBase;
    doSched  = busy & pendNow & ~sched;
    effSched = sched | doSched;
    effW     = doSched ? wCand : wK;
    effMask  = doSched ? cutNew : maskOn;
    effDqmK  = doSched ? (lFin - K_W'(1)) : dqmK;
    endRead  = busy & ~effSched & (k > lastK);

    stb         = '0;
    stb.capWr   = wrStart & ~wrPend;
    stb.issueRd = ~busy & rdStart;
    stb.issueWr = busy ? (effSched & (kNext == effW)) : (~rdStart & pendNow);
    stb.wrCut   = busy & stb.issueWr & effMask;
    stb.dqmNext = busy & effSched & effMask & (kNext >= effDqmK) & (kNext < effW);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sched  <= 1'b0;
      maskOn <= 1'b0;
      wrPend <= 1'b0;
      k      <= '0;
      wK     <= '0;
      dqmK   <= '0;
      lastK  <= '0;
    end else begin
      busy   <= stb.issueRd | (busy & ~stb.issueWr & ~endRead);
      wrPend <= pendNow & ~stb.issueWr;
      sched  <= busy & effSched & ~stb.issueWr;
      if (stb.issueRd) begin
        k     <= '0;
        lastK <= CL_K + K_W'(rdLen) - K_W'(1);
      end else if (busy) begin
        k <= kNext;
      end
      if (doSched) begin
        wK     <= wCand;
        dqmK   <= lFin - K_W'(1);
        maskOn <= cutNew;
      end
    end
  end

  // R1: read and write never go out in the same cycle
  p_single_issue_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.issueRd && stb.issueWr));

  // R3: a scheduled write always lies ahead of the current cycle
  p_target_ahead_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sched) |-> (wK > k));

  // R4: the mask window opens before the write cycle
  p_mask_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && sched && maskOn) |-> (dqmK < wK));

endmodule

// File: rtl/rdwr_turn_dp.sv
module rdwr_turn_dp
  import rdwr_turn_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [BANK_W-1:0] rdBank,
  input  logic [COL_W-1:0]  rdCol,
  input  logic [BANK_W-1:0] wrBank,
  input  logic [COL_W-1:0]  wrCol,
  input  logic [DATA_W-1:0] wrData,
  output logic [2:0]        cmdOut,
  output logic [BANK_W-1:0] bankOut,
  output logic [COL_W-1:0]  addrOut,
  output logic              dqmOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] dqOut
);

  logic [BANK_W-1:0] wrBankQ, selBank;
  logic [COL_W-1:0]  wrColQ, selCol;
  logic [DATA_W-1:0] wrDataQ, selData;
  sdCmd_e            cmdQ;

  always_comb begin
    selBank = stb.capWr ? wrBank : wrBankQ;
    selCol  = stb.capWr ? wrCol  : wrColQ;
    selData = stb.capWr ? wrData : wrDataQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrBankQ <= '0;
      wrColQ  <= '0;
      wrDataQ <= '0;
      cmdQ    <= CMD_NOP;
      bankOut <= '0;
      addrOut <= '0;
      dqmOut  <= 1'b0;
      dqOe    <= 1'b0;
      dqOut   <= '0;
    end else begin
      if (stb.capWr) begin
        wrBankQ <= wrBank;
        wrColQ  <= wrCol;
        wrDataQ <= wrData;
      end
      dqmOut <= stb.dqmNext;
      dqOe   <= stb.issueWr;
      dqOut  <= stb.issueWr ? selData : '0;
      if (stb.issueRd) begin
        cmdQ    <= CMD_READ;
        bankOut <= rdBank;
        addrOut <= rdCol;
      end else if (stb.issueWr) begin
        cmdQ    <= CMD_WRITE;
        bankOut <= selBank;
        addrOut <= selCol;
      end else begin
        cmdQ    <= CMD_NOP;
        bankOut <= '0;
        addrOut <= '0;
      end
    end
  end

  assign cmdOut = cmdQ;

  // R4: a truncating WRITE is preceded by a masked cycle
  p_dqm_prior_r4: assert property (@(posedge clk) disable iff (!rstN)
    (stb.issueWr && stb.wrCut) |-> dqmOut);

  // R5: write data is never masked in the command cycle
  p_wr_unmasked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdQ == CMD_WRITE) |-> !dqmOut);

  // R7: the pins are driven only alongside a WRITE
  p_oe_with_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> (cmdQ == CMD_WRITE));

endmodule

// File: rtl/rdwr_turnaround.sv
module rdwr_turnaround
  import rdwr_turn_pkg::*;
#(
  parameter int CAS_LAT = 3,
  parameter int BL_MAX  = 8,
  parameter int BANK_W  = 2,
  parameter int COL_W   = 10,
  parameter int DATA_W  = 16,
  parameter int LEN_W   = $clog2(BL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdStart,
  input  logic [BANK_W-1:0] rdBank,
  input  logic [COL_W-1:0]  rdCol,
  input  logic [LEN_W-1:0]  rdLen,
  input  logic              wrStart,
  input  logic [BANK_W-1:0] wrBank,
  input  logic [COL_W-1:0]  wrCol,
  input  logic [DATA_W-1:0] wrData,
  input  logic              cfgGap,
  output logic [2:0]        cmdOut,
  output logic [BANK_W-1:0] bankOut,
  output logic [COL_W-1:0]  addrOut,
  output logic              dqmOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] dqOut
);

  seqStrobe_t stb;

  rdwr_turn_ctrl #(
    .CAS_LAT(CAS_LAT), .BL_MAX(BL_MAX), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .rdStart(rdStart), .rdLen(rdLen),
    .wrStart(wrStart), .cfgGap(cfgGap), .stb(stb)
  );

  rdwr_turn_dp #(
    .BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rdBank(rdBank), .rdCol(rdCol),
    .wrBank(wrBank), .wrCol(wrCol), .wrData(wrData),
    .cmdOut(cmdOut), .bankOut(bankOut), .addrOut(addrOut),
    .dqmOut(dqmOut), .dqOe(dqOe), .dqOut(dqOut)
  );

endmodule

// File: tb/rdwr_turnaround_bench.sv
module rdwr_turnaround_bench;
  localparam int CL  = 3;
  localparam int BLM = 8;
  localparam int BW  = 2;
  localparam int CW  = 10;
  localparam int DW  = 16;
  localparam int LW  = $clog2(BLM + 1);
  localparam int WIN = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdStart = 1'b0, wrStart = 1'b0, cfgGap = 1'b0;
  logic [BW-1:0] rdBank = '0, wrBank = '0, bankOut;
  logic [CW-1:0] rdCol = '0, wrCol = '0, addrOut;
  logic [LW-1:0] rdLen = LW'(1);
  logic [DW-1:0] wrData = '0, dqOut;
  logic [2:0]    cmdOut;
  logic          dqmOut, dqOe;

  int nVec = 0, nBad = 0, cyc = 0;
  int cmdA[0:WIN], dqmA[0:WIN], oeA[0:WIN], bankA[0:WIN], addrA[0:WIN], dataA[0:WIN];

  always #5 clk = ~clk;

  rdwr_turnaround #(.CAS_LAT(CL), .BL_MAX(BLM), .BANK_W(BW), .COL_W(CW), .DATA_W(DW))
    u_rdwr_turnaround (
      .clk(clk), .rstN(rstN), .rdStart(rdStart), .rdBank(rdBank), .rdCol(rdCol),
      .rdLen(rdLen), .wrStart(wrStart), .wrBank(wrBank), .wrCol(wrCol),
      .wrData(wrData), .cfgGap(cfgGap), .cmdOut(cmdOut), .bankOut(bankOut),
      .addrOut(addrOut), .dqmOut(dqmOut), .dqOe(dqOe), .dqOut(dqOut));

  task automatic chk(input string tag, input int act, input int exp);
    nVec++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog R1 actual=%0d expected=<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  task automatic run_case(input int gap, input int len, input int j);
    int lastK, jE, L, W, dupT, nUnm, rb, rc, wb, wc, wd;
    bit cut, dup, unm;
    lastK = CL + len - 1;
    jE    = (j < 0) ? 0 : j;
    L     = (jE + 2 > CL) ? jE + 2 : CL;
    if (L > lastK) L = lastK;
    cut   = L < lastK;
    W     = (L + 1 + gap > jE + 1) ? L + 1 + gap : jE + 1;
    dupT  = jE + 1;
    dup   = dupT < W;
    rb = (len + j + 5) % 4;  rc = 37 * len + j + 11;
    wb = (len + 2 * j + 7) % 4; wc = 500 + 13 * len + j + gap;
    wd = 16'h1000 + 97 * len + 7 * (j + 1) + 4096 * gap;

    @(negedge clk);
    cfgGap = gap[0]; rdStart = 1'b1; rdBank = BW'(rb); rdCol = CW'(rc); rdLen = LW'(len);
    wrStart = (j == -1); wrBank = BW'(wb); wrCol = CW'(wc); wrData = DW'(wd);
    for (int t = 0; t <= WIN; t++) begin
      @(negedge clk);
      cmdA[t] = int'(cmdOut); dqmA[t] = int'(dqmOut); oeA[t] = int'(dqOe);
      bankA[t] = int'(bankOut); addrA[t] = int'(addrOut); dataA[t] = int'(dqOut);
      rdStart = (t == 1);           // R8: ignored, read in flight
      rdBank  = BW'(rb + 1);
      wrStart = (t == j) || (dup && t == dupT);
      if (dup && t == dupT) wrData = DW'(~wd);
    end
    rdStart = 1'b0; wrStart = 1'b0;
    repeat (3) @(negedge clk);

    // R1: READ in cycle 0 with its bank and column
    chk("R1 read cmd", cmdA[0], 3'b101);
    chk("R1 read bank", bankA[0], rb);
    chk("R1 read col", addrA[0], rc % 1024);
    // R3 / R7: write cycle, fields and data
    chk("R3 write cmd", cmdA[W], 3'b100);
    chk("R3 write bank", bankA[W], wb);
    chk("R3 write col", addrA[W], wc % 1024);
    chk("R8 first write data kept", dataA[W], wd % 65536);
    chk("R5 dqm low at write", dqmA[W], 0);
    for (int t = 1; t <= WIN; t++) begin
      if (t != W) begin
        chk("R1 nop elsewhere", cmdA[t], 3'b111);
        chk("R7 oe only at write", oeA[t], 0);
      end
      if (t != W) chk("R4 R6 dqm window", dqmA[t], (cut && t >= L - 1 && t < W) ? 1 : 0);
    end
    // R2 / R7: rebuild the memory's unmasked read words
    nUnm = 0;
    for (int t = CL; t <= lastK; t++) begin
      unm = (dqmA[t-2] == 0) && (t < W);
      if (unm) nUnm++;
      if (unm && oeA[t] != 0) chk("R7 contention", 1, 0);
      if (unm && gap == 1 && t == W - 1) chk("R7 gap cycle busy", 1, 0);
    end
    chk("R2 delivered read words", nUnm, L - CL + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset cmd", int'(cmdOut), 3'b111);
    chk("R1 reset dqm", int'(dqmOut), 0);
    chk("R1 reset oe", int'(dqOe), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R8: write from idle goes out the next cycle
    wrStart = 1'b1; wrBank = 2'd3; wrCol = 10'd777; wrData = 16'hBEEF;
    @(negedge clk);
    wrStart = 1'b0;
    chk("R8 idle write cmd", int'(cmdOut), 3'b100);
    chk("R8 idle write oe", int'(dqOe), 1);
    chk("R8 idle write data", int'(dqOut), 16'hBEEF);
    chk("R5 idle write dqm", int'(dqmOut), 0);
    @(negedge clk);
    chk("R7 oe drops after write", int'(dqOe), 0);
    chk("R1 nop after write", int'(cmdOut), 3'b111);
    repeat (2) @(negedge clk);

    for (int gap = 0; gap <= 1; gap++)
      for (int len = 1; len <= BLM; len++)
        for (int j = -1; j <= CL + len + 1; j++)
          run_case(gap, len, j);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule